// File: doc/BRIEF.md
# Register Alias Rename Table

This block keeps track of which in-flight result slot will produce the newest value of each architectural register. It holds one entry per register across three classes: eight integer registers, eight floating-point registers and a single flags register. Each entry is either empty, meaning the value sits in the committed register file, or holds the 5-bit tag of the reorder-buffer slot that will write it.

Up to two micro-operations arrive per cycle in program order. Lane 0 is the older one. Each carries two source operands and an optional destination with a slot tag supplied by the reorder buffer. Sources are looked up combinationally in the same cycle. Destinations update the table at the clock edge. When lane 1 reads the register that lane 0 writes in the same cycle, lane 1 receives lane 0's new tag. The reorder buffer reports one retirement per cycle. If the retiring tag is still the newest mapping for its register, that register falls back to the committed file. A flush from a mispredicted branch or a fault empties the whole table in a single cycle.

Top module: `rename_alias_table`

## Requirements
- R1: After reset every register reads as committed (pending flag 0).
- R2: Integer, floating-point and flags registers are separate entries. A rename of integer register n leaves floating-point register n unchanged.
- R3: A source whose register was renamed in an earlier cycle, with no later flush or clearing retirement, reads pending = 1 with the tag of the newest rename. Pending = 0 means the committed file, and the tag output is then meaningless.
- R4: Class code 0 selects integer, 1 selects floating point, and 2 or 3 select the single flags register, for which the index is ignored.
- R5: A lane 1 source that names the register written by a valid lane 0 destination in the same cycle reads pending = 1 with lane 0's destination tag.
- R6: A retirement whose class, index and tag match a pending entry clears it at the next edge. A retirement whose tag does not match leaves the entry unchanged.
- R7: A flush makes every entry read as committed from the next cycle on. Renames and retirements presented in the flush cycle are discarded.
- R8: When a retirement and a rename target the same register in the same cycle, the rename wins and the entry holds the new tag.
- R9: When both lanes rename the same register in one cycle, the entry takes lane 1's tag.
- R10: Lookups show the table as it stood at the start of the cycle. A lane 0 source does not see a rename made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_cls | input | 4x2 | Source class per operand (0,1 lane 0; 2,3 lane 1) |
| src_idx | input | 4xIDX_W | Source register index per operand |
| src_pend | output | 4 | Source is waiting on an in-flight slot |
| src_tag | output | 4xTAG_W | Slot tag of the producer when pending |
| dst_vld | input | 2 | Destination present per lane |
| dst_cls | input | 2x2 | Destination class per lane |
| dst_idx | input | 2xIDX_W | Destination index per lane |
| dst_tag | input | 2xTAG_W | New slot tag per lane |
| ret_vld | input | 1 | Retirement notification valid |
| ret_cls | input | 2 | Retiring destination class |
| ret_idx | input | IDX_W | Retiring destination index |
| ret_tag | input | TAG_W | Retiring slot tag |
| flush | input | 1 | Discard all speculative mappings |

## Verification
Renames and retirements can hit the same register in the same cycle. So can a flush and pending renames. The bench provokes the first case directly: it retires the live tag of a register while renaming that register again. It provokes both cases at random by drawing retirement tags from the reference model's current mapping about half the time. After each edge, it checks the next cycle's lookups against a behavioural model. That model applies the retirement before the renames, and it applies a flush over everything else.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_FLG  = 2'd2,
    CLS_FLG2 = 2'd3
  } reg_cls_e;

  localparam int LANES = 2;
  localparam int SRCS_PER_LANE = 2;
  localparam int NOPS = LANES * SRCS_PER_LANE;
endpackage

// File: rtl/rat_flat_index.sv
module rat_flat_index #(
  parameter int NUM_INT = 8,
  parameter int NUM_FP  = 8,
  parameter int IDX_W   = 3,
  parameter int FLAT_W  = 5
) (
  input  logic [1:0]        cls,
  input  logic [IDX_W-1:0]  idx,
  output logic [FLAT_W-1:0] flat
);
  import rat_pkg::*;

  localparam logic [FLAT_W-1:0] FP_BASE  = FLAT_W'(NUM_INT);
  localparam logic [FLAT_W-1:0] FLG_SLOT = FLAT_W'(NUM_INT + NUM_FP);

  always_comb begin
    if (cls[1])                   flat = FLG_SLOT;
    else if (cls == 2'(CLS_FP))   flat = FP_BASE + FLAT_W'(idx);
    else                          flat = FLAT_W'(idx);
  end
endmodule

// File: rtl/rat_store.sv
module rat_store #(
  parameter int NREG   = 17,
  parameter int TAG_W  = 5,
  parameter int FLAT_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [1:0]                   wr_vld,
  input  logic [1:0][FLAT_W-1:0]       wr_flat,
  input  logic [1:0][TAG_W-1:0]        wr_tag,
  input  logic                         ret_vld,
  input  logic [FLAT_W-1:0]            ret_flat,
  input  logic [TAG_W-1:0]             ret_tag,
  output logic [NREG-1:0]              ent_v,
  output logic [NREG-1:0][TAG_W-1:0]   ent_tag
);
  for (genvar r = 0; r < NREG; r++) begin : g_ent
    logic             v_q, v_d;
    logic [TAG_W-1:0] t_q, t_d;
    logic             t_en;
    logic             hit0, hit1, hit_ret;

    assign hit0    = wr_vld[0] && (wr_flat[0] == FLAT_W'(r));
    assign hit1    = wr_vld[1] && (wr_flat[1] == FLAT_W'(r));
    assign hit_ret = ret_vld && (ret_flat == FLAT_W'(r)) && v_q && (t_q == ret_tag);

    always_comb begin
      v_d  = v_q;
      t_d  = t_q;
      t_en = 1'b0;
      if (flush) begin
        v_d = 1'b0;
      end else if (hit1) begin
        v_d  = 1'b1;
        t_d  = wr_tag[1];
        t_en = 1'b1;
      end else if (hit0) begin
        v_d  = 1'b1;
        t_d  = wr_tag[0];
        t_en = 1'b1;
      end else if (hit_ret) begin
        v_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (t_en) t_q <= t_d;
    end

    assign ent_v[r]   = v_q;
    assign ent_tag[r] = t_q;
  end
endmodule

// File: rtl/rat_lookup.sv
module rat_lookup #(
  parameter int NREG   = 17,
  parameter int TAG_W  = 5,
  parameter int FLAT_W = 5
) (
  input  logic [FLAT_W-1:0]           rd_flat,
  input  logic [NREG-1:0]             ent_v,
  input  logic [NREG-1:0][TAG_W-1:0]  ent_tag,
  input  logic                        byp_vld,
  input  logic [FLAT_W-1:0]           byp_flat,
  input  logic [TAG_W-1:0]            byp_tag,
  output logic                        pend,
  output logic [TAG_W-1:0]            tag
);
  always_comb begin
    if (byp_vld && (byp_flat == rd_flat)) begin
      pend = 1'b1;
      tag  = byp_tag;
    end else begin
      pend = ent_v[rd_flat];
      tag  = ent_tag[rd_flat];
    end
  end
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table #(
  parameter int NUM_INT = 8,
  parameter int NUM_FP  = 8,
  parameter int IDX_W   = 3,
  parameter int TAG_W   = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0][1:0]        src_cls,
  input  logic [3:0][IDX_W-1:0]  src_idx,
  output logic [3:0]             src_pend,
  output logic [3:0][TAG_W-1:0]  src_tag,
  input  logic [1:0]             dst_vld,
  input  logic [1:0][1:0]        dst_cls,
  input  logic [1:0][IDX_W-1:0]  dst_idx,
  input  logic [1:0][TAG_W-1:0]  dst_tag,
  input  logic                   ret_vld,
  input  logic [1:0]             ret_cls,
  input  logic [IDX_W-1:0]       ret_idx,
  input  logic [TAG_W-1:0]       ret_tag,
  input  logic                   flush
);
  import rat_pkg::*;

  localparam int NREG   = NUM_INT + NUM_FP + 1;
  localparam int FLAT_W = $clog2(NREG);

  logic [NREG-1:0]             ent_v;
  logic [NREG-1:0][TAG_W-1:0]  ent_tag;
  logic [1:0][FLAT_W-1:0]      dst_flat;
  logic [FLAT_W-1:0]           ret_flat;

  for (genvar l = 0; l < LANES; l++) begin : g_dst
    rat_flat_index #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W), .FLAT_W(FLAT_W))
      u_dmap (.cls(dst_cls[l]), .idx(dst_idx[l]), .flat(dst_flat[l]));
  end

  rat_flat_index #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W), .FLAT_W(FLAT_W))
    u_rmap (.cls(ret_cls), .idx(ret_idx), .flat(ret_flat));

  rat_store #(.NREG(NREG), .TAG_W(TAG_W), .FLAT_W(FLAT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_vld(dst_vld), .wr_flat(dst_flat), .wr_tag(dst_tag),
    .ret_vld(ret_vld), .ret_flat(ret_flat), .ret_tag(ret_tag),
    .ent_v(ent_v), .ent_tag(ent_tag)
  );

  for (genvar o = 0; o < NOPS; o++) begin : g_src
    logic [FLAT_W-1:0] s_flat;
    logic              byp_en;

    rat_flat_index #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W), .FLAT_W(FLAT_W))
      u_smap (.cls(src_cls[o]), .idx(src_idx[o]), .flat(s_flat));

    if (o >= SRCS_PER_LANE) begin : g_byp
      assign byp_en = dst_vld[0];
    end else begin : g_nobyp
      assign byp_en = 1'b0;
    end

    rat_lookup #(.NREG(NREG), .TAG_W(TAG_W), .FLAT_W(FLAT_W)) u_look (
      .rd_flat(s_flat), .ent_v(ent_v), .ent_tag(ent_tag),
      .byp_vld(byp_en), .byp_flat(dst_flat[0]), .byp_tag(dst_tag[0]),
      .pend(src_pend[o]), .tag(src_tag[o])
    );
  end
endmodule

// File: rtl/rat_checker.sv
module rat_checker #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [3:0][1:0]        src_cls,
  input logic [3:0][IDX_W-1:0]  src_idx,
  input logic [3:0]             src_pend,
  input logic [3:0][TAG_W-1:0]  src_tag,
  input logic [1:0]             dst_vld,
  input logic [1:0][1:0]        dst_cls,
  input logic [1:0][IDX_W-1:0]  dst_idx,
  input logic [1:0][TAG_W-1:0]  dst_tag,
  input logic                   ret_vld,
  input logic [1:0]             ret_cls,
  input logic [IDX_W-1:0]       ret_idx,
  input logic [TAG_W-1:0]       ret_tag,
  input logic                   flush
);
  function automatic logic same_reg(logic [1:0] ca, logic [IDX_W-1:0] ia,
                                    logic [1:0] cb, logic [IDX_W-1:0] ib);
    return (ca[1] && cb[1]) || (!ca[1] && (ca == cb) && (ia == ib));
  endfunction

  logic ret_hit_by_dst;
  assign ret_hit_by_dst = (dst_vld[0] && same_reg(dst_cls[0], dst_idx[0], ret_cls, ret_idx)) ||
                          (dst_vld[1] && same_reg(dst_cls[1], dst_idx[1], ret_cls, ret_idx));

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (!src_pend[0] && !src_pend[1]));

  for (genvar o = 2; o < 4; o++) begin : g_byp_chk
    assert_lane_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_vld[0] && same_reg(dst_cls[0], dst_idx[0], src_cls[o], src_idx[o]))
      |-> (src_pend[o] && src_tag[o] == dst_tag[0]));
  end

  for (genvar o = 0; o < 2; o++) begin : g_new_chk
    assert_newest_rename_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(flush) && $past(dst_vld[1]) &&
       same_reg(src_cls[o], src_idx[o], $past(dst_cls[1]), $past(dst_idx[1])))
      |-> (src_pend[o] && src_tag[o] == $past(dst_tag[1])));
  end

  assert_younger_lane_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(flush) && $past(dst_vld[0]) &&
     same_reg(src_cls[0], src_idx[0], $past(dst_cls[0]), $past(dst_idx[0])) &&
     !($past(dst_vld[1]) && same_reg(src_cls[0], src_idx[0], $past(dst_cls[1]), $past(dst_idx[1]))))
    |-> (src_pend[0] && src_tag[0] == $past(dst_tag[0])));

  assert_retire_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(flush) && $past(ret_vld) && !$past(ret_hit_by_dst) &&
     $past(src_pend[0]) && ($past(src_tag[0]) == $past(ret_tag)) &&
     $past(same_reg(src_cls[0], src_idx[0], ret_cls, ret_idx)) &&
     same_reg(src_cls[0], src_idx[0], $past(ret_cls), $past(ret_idx)))
    |-> !src_pend[0]);

  assert_rename_beats_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(flush) && $past(ret_vld) && $past(ret_hit_by_dst) &&
     same_reg(src_cls[0], src_idx[0], $past(ret_cls), $past(ret_idx)))
    |-> src_pend[0]);
endmodule

bind rename_alias_table rat_checker #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_cls(src_cls), .src_idx(src_idx),
  .src_pend(src_pend), .src_tag(src_tag), .dst_vld(dst_vld), .dst_cls(dst_cls),
  .dst_idx(dst_idx), .dst_tag(dst_tag), .ret_vld(ret_vld), .ret_cls(ret_cls),
  .ret_idx(ret_idx), .ret_tag(ret_tag), .flush(flush)
);

// File: tb/rename_alias_table_test.sv
`timescale 1ns/1ps
module rename_alias_table_test;
  localparam int IDX_W = 3;
  localparam int TAG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0][1:0]        src_cls = '0;
  logic [3:0][IDX_W-1:0]  src_idx = '0;
  logic [3:0]             src_pend;
  logic [3:0][TAG_W-1:0]  src_tag;
  logic [1:0]             dst_vld = '0;
  logic [1:0][1:0]        dst_cls = '0;
  logic [1:0][IDX_W-1:0]  dst_idx = '0;
  logic [1:0][TAG_W-1:0]  dst_tag = '0;
  logic                   ret_vld = 1'b0;
  logic [1:0]             ret_cls = '0;
  logic [IDX_W-1:0]       ret_idx = '0;
  logic [TAG_W-1:0]       ret_tag = '0;
  logic                   flush = 1'b0;

  int vectors = 0;
  int errors = 0;
  int mv[17];
  int mt[17];

  always #10 clk = ~clk;

  rename_alias_table uut (
    .clk(clk), .rst_n(rst_n), .src_cls(src_cls), .src_idx(src_idx),
    .src_pend(src_pend), .src_tag(src_tag), .dst_vld(dst_vld), .dst_cls(dst_cls),
    .dst_idx(dst_idx), .dst_tag(dst_tag), .ret_vld(ret_vld), .ret_cls(ret_cls),
    .ret_idx(ret_idx), .ret_tag(ret_tag), .flush(flush)
  );

  function automatic int key(logic [1:0] c, logic [IDX_W-1:0] i);
    if (c >= 2) return 16;
    return int'(c) * 8 + int'(i);
  endfunction

  task automatic idle();
    dst_vld = '0; ret_vld = 1'b0; flush = 1'b0;
  endtask

  task automatic set_src(int o, int c, int i);
    src_cls[o] = 2'(c); src_idx[o] = IDX_W'(i);
  endtask

  task automatic set_dst(int l, int c, int i, int t);
    dst_vld[l] = 1'b1; dst_cls[l] = 2'(c); dst_idx[l] = IDX_W'(i); dst_tag[l] = TAG_W'(t);
  endtask

  task automatic set_ret(int c, int i, int t);
    ret_vld = 1'b1; ret_cls = 2'(c); ret_idx = IDX_W'(i); ret_tag = TAG_W'(t);
  endtask

  task automatic check(string req);
    for (int o = 0; o < 4; o++) begin
      int k = key(src_cls[o], src_idx[o]);
      int ep = mv[k];
      int et = mt[k];
      string r = req;
      if (o >= 2 && dst_vld[0] && key(dst_cls[0], dst_idx[0]) == k) begin
        ep = 1; et = int'(dst_tag[0]); r = "R5";
      end
      vectors++;
      if (int'(src_pend[o]) != ep || (ep == 1 && int'(src_tag[o]) != et)) begin
        errors++;
        $display("FAIL %s operand %0d: pend=%0d tag=%0d expected pend=%0d tag=%0d",
                 r, o, src_pend[o], src_tag[o], ep, et);
      end
    end
  endtask

  task automatic model_update();
    if (flush) begin
      for (int k = 0; k < 17; k++) mv[k] = 0;
    end else begin
      if (ret_vld) begin
        int kr = key(ret_cls, ret_idx);
        if (mv[kr] == 1 && mt[kr] == int'(ret_tag)) mv[kr] = 0;
      end
      for (int l = 0; l < 2; l++)
        if (dst_vld[l]) begin
          mv[key(dst_cls[l], dst_idx[l])] = 1;
          mt[key(dst_cls[l], dst_idx[l])] = int'(dst_tag[l]);
        end
    end
  endtask

  task automatic step(string req);
    #5;
    check(req);
    model_update();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 17; k++) begin mv[k] = 0; mt[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all committed after reset
    set_src(0, 0, 0); set_src(1, 1, 7); set_src(2, 2, 0); set_src(3, 0, 5);
    step("R1");
    // R10: same-cycle rename not visible to lane 0
    idle(); set_dst(0, 0, 3, 5); set_src(0, 0, 3); set_src(1, 1, 3);
    step("R10");
    // R2/R3: integer r3 pending, fp r3 committed
    idle(); set_src(0, 0, 3); set_src(1, 1, 3); set_dst(1, 1, 3, 9);
    step("R2");
    idle(); set_src(0, 1, 3); set_src(1, 0, 3);
    step("R3");
    // R4: flags ignores index
    idle(); set_dst(0, 2, 5, 7);
    step("R4");
    idle(); set_src(0, 3, 0); set_src(1, 2, 6);
    step("R4");
    // R5: lane 1 bypass
    idle(); set_dst(0, 0, 1, 11); set_src(2, 0, 1); set_src(3, 1, 1);
    step("R5");
    // R9: both lanes same destination
    idle(); set_dst(0, 0, 2, 12); set_dst(1, 0, 2, 13);
    step("R9");
    idle(); set_src(0, 0, 2);
    step("R9");
    // R6: mismatched retirement ignored, matching one clears
    idle(); set_ret(0, 2, 12); set_src(0, 0, 2);
    step("R6");
    idle(); set_ret(0, 2, 13); set_src(0, 0, 2);
    step("R6");
    idle(); set_src(0, 0, 2);
    step("R6");
    // R8: retirement and rename of the same register
    idle(); set_ret(0, 3, 5); set_dst(0, 0, 3, 20);
    step("R8");
    idle(); set_src(0, 0, 3);
    step("R8");
    // R7: flush discards same-cycle rename
    idle(); flush = 1'b1; set_dst(0, 0, 4, 1); set_ret(2, 0, 7);
    step("R7");
    idle(); set_src(0, 0, 4); set_src(1, 0, 3); set_src(2, 2, 0); set_src(3, 1, 3);
    step("R7");
    // R3: random mixture compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      idle();
      for (int o = 0; o < 4; o++) set_src(o, $urandom_range(0, 3), $urandom_range(0, 7));
      for (int l = 0; l < 2; l++)
        if ($urandom_range(0, 2) != 0)
          set_dst(l, $urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 31));
      if ($urandom_range(0, 1) == 1) begin
        int c = $urandom_range(0, 3);
        int i = $urandom_range(0, 7);
        int t = ($urandom_range(0, 1) == 1) ? mt[key(2'(c), IDX_W'(i))] : $urandom_range(0, 31);
        set_ret(c, i, t);
      end
      flush = ($urandom_range(0, 24) == 0);
      step("R3");
    end
    finish_run();
  end
endmodule